// File: doc/BRIEF.md
# Backup-Battery Rail Switchover and Storage-Seal Controller

This controller decides which source feeds a retained-RAM supply rail: the main supply or a backup cell. It reads digital comparator flags (main supply above the reset threshold, main supply above the cell voltage, and main supply below an absolute working minimum). From these it drives select lines for two external power switches. Every change of source passes through one cycle with both switches open, so the two sources are never joined.

For shipping, a storage seal keeps the cell disconnected until the product is first powered in earnest. The seal is armed by a pin-strap sequence, checked against a millisecond tick, and cleared by the first rising edge of the system reset that occurs while the supply is good. The power-fail comparator flag is also passed straight through to the power-fail output pin.

Two state machines do the work. The switch machine has the states SW_MAIN, SW_BREAK and SW_BATT. Its transitions are: SW_MAIN to SW_BREAK when the cell is wanted, SW_BATT to SW_BREAK when it is no longer wanted, and SW_BREAK to whichever source is wanted next. The seal machine has the states SL_IDLE, SL_QUAL, SL_OVER and SL_SEALED. Its transitions are:
- SL_IDLE to SL_QUAL when the strap conditions appear.
- SL_QUAL to SL_SEALED when the conditions end within the window.
- SL_QUAL to SL_IDLE when they end too early.
- SL_QUAL to SL_OVER when they outlast the window.
- SL_OVER to SL_IDLE when they end.
- SL_SEALED to SL_IDLE on a reset rising edge with the supply good.

Top module: `bkup_rail_ctrl`

## Requirements
- R1: With the supply not below minimum and unsealed, the cell is wanted only when sup_ok=0 and sup_gt_bat=0; in the other three combinations the main supply is wanted.
- R2: With sup_dead=1 and unsealed, the cell is wanted whatever sup_gt_bat says.
- R3: sel_main and sel_bat are never both 1. A change of the wanted source seen at clock edge k gives both selects 0 after edge k, and the new select 1 after edge k+1.
- R4: When the rail is on the cell, it moves back to main as soon as either sup_ok or sup_gt_bat goes to 1, whichever comes first, with the R3 timing.
- R5: The strap condition is pf_pin_low=1, pf_cmp=1 and sup_ok=1. If it ends after the number of ms_tick pulses seen during SL_QUAL is between SEAL_MIN_MS (5) and SEAL_MAX_MS (35) inclusive, the block becomes sealed.
- R6: If the strap condition ends with fewer than SEAL_MIN_MS ticks counted, or a tick arrives while the count is already SEAL_MAX_MS, the block stays unsealed. A new attempt starts from a count of zero only after the condition has gone away.
- R7: While sealed, sel_bat is never 1, even with sup_ok=0 and sup_gt_bat=0.
- R8: The seal is cleared by a 0-to-1 change of sys_rst_n sampled while sup_ok=1. A rising edge while sup_ok=0 leaves it set.
- R9: pf_out equals pf_cmp combinationally.
- R10: During rst_n=0 both selects are 0 and the seal is clear. After release, the first edge selects the wanted source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| sup_ok | input | 1 | Main supply above the reset threshold |
| sup_gt_bat | input | 1 | Main supply above the cell voltage |
| sup_dead | input | 1 | Main supply below the absolute working minimum |
| pf_cmp | input | 1 | Power-fail comparator: monitored input above its reference |
| pf_pin_low | input | 1 | Power-fail output pin sensed low (held down externally) |
| sys_rst_n | input | 1 | Active-low reset from the reset sequencer |
| sel_main | output | 1 | Closes the main-supply switch |
| sel_bat | output | 1 | Closes the backup-cell switch |
| pf_out | output | 1 | Power-fail output, high when the monitored input is above reference |

## Verification
The switch is driven through all four threshold and cell-comparison combinations, and through the forced-minimum case with the cell comparison both ways. This separates a one-flag decision from the required two-flag decision. Recovery is run twice, once with the cell comparison rising first and once with the threshold rising first, so that a design waiting on only one of them is exposed. The seal is tried with a strap held too briefly, one held past the window and one held inside the window, and then with reset edges under a bad and a good supply. Together these show the window bounds, the restart, and the clearing condition at the select pins.

// File: rtl/rail_pkg.sv
package rail_pkg;
    typedef enum logic [1:0] {SW_MAIN, SW_BREAK, SW_BATT} sw_state_t;
    typedef enum logic [1:0] {SL_IDLE, SL_QUAL, SL_OVER, SL_SEALED} seal_state_t;
endpackage

// File: rtl/rail_sel_fsm.sv
module rail_sel_fsm
    import rail_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_bat,
    output logic sel_main,
    output logic sel_bat
);
    sw_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SW_MAIN:  if (want_bat) state_nx = SW_BREAK;
            SW_BATT:  if (!want_bat) state_nx = SW_BREAK;
            SW_BREAK: state_nx = want_bat ? SW_BATT : SW_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SW_BREAK;
        else        state <= state_nx;
    end

    always_comb begin
        sel_main = (state == SW_MAIN);
        sel_bat  = (state == SW_BATT);
    end

    assert_sel_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_main && sel_bat));
    assert_main_breaks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_main |=> !sel_bat);
    assert_batt_breaks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_bat |=> !sel_main);
    assert_leave_main_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_main && want_bat) |=> (!sel_main && !sel_bat));
    assert_gap_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_main && !sel_bat) |=> (sel_main || sel_bat));
endmodule

// File: rtl/seal_fsm.sv
module seal_fsm
    import rail_pkg::*;
#(
    parameter int SEAL_MIN_MS = 5,
    parameter int SEAL_MAX_MS = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic strap_on,
    input  logic sup_ok,
    input  logic sys_rst_n,
    output logic sealed
);
    localparam int CW = $clog2(SEAL_MAX_MS + 1);

    seal_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          prev_rst;
    logic          rst_rise;

    assign rst_rise = sys_rst_n && !prev_rst;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SL_IDLE: begin
                cnt_nx = '0;
                if (strap_on) state_nx = SL_QUAL;
            end
            SL_QUAL: begin
                if (!strap_on)
                    state_nx = (cnt >= CW'(SEAL_MIN_MS)) ? SL_SEALED : SL_IDLE;
                else if (ms_tick) begin
                    if (cnt == CW'(SEAL_MAX_MS)) state_nx = SL_OVER;
                    else                         cnt_nx   = cnt + 1'b1;
                end
            end
            SL_OVER:   if (!strap_on) state_nx = SL_IDLE;
            SL_SEALED: if (rst_rise && sup_ok) state_nx = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SL_IDLE;
            cnt      <= '0;
            prev_rst <= 1'b1;
        end else begin
            state    <= state_nx;
            cnt      <= cnt_nx;
            prev_rst <= sys_rst_n;
        end
    end

    always_comb sealed = (state == SL_SEALED);

    assert_seal_from_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sealed) |-> $past(state == SL_QUAL));
    assert_seal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed && $rose(sys_rst_n) && sup_ok) |=> !sealed);
    assert_seal_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed && !sup_ok) |=> sealed);
endmodule

// File: rtl/bkup_rail_ctrl.sv
module bkup_rail_ctrl #(
    parameter int SEAL_MIN_MS = 5,
    parameter int SEAL_MAX_MS = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic sup_ok,
    input  logic sup_gt_bat,
    input  logic sup_dead,
    input  logic pf_cmp,
    input  logic pf_pin_low,
    input  logic sys_rst_n,
    output logic sel_main,
    output logic sel_bat,
    output logic pf_out
);
    logic sealed;
    logic strap_on;
    logic want_bat;

    assign strap_on = pf_pin_low && pf_cmp && sup_ok;
    assign want_bat = !sealed && (sup_dead || (!sup_ok && !sup_gt_bat));
    assign pf_out   = pf_cmp;

    seal_fsm #(
        .SEAL_MIN_MS(SEAL_MIN_MS),
        .SEAL_MAX_MS(SEAL_MAX_MS)
    ) u_seal (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .strap_on (strap_on),
        .sup_ok   (sup_ok),
        .sys_rst_n(sys_rst_n),
        .sealed   (sealed)
    );

    rail_sel_fsm u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_bat(want_bat),
        .sel_main(sel_main),
        .sel_bat (sel_bat)
    );

    assert_sealed_no_batt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |-> !sel_bat);
    assert_recover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bat && (sup_ok || sup_gt_bat) && !sup_dead) |=> !sel_bat);
    assert_dead_batt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_main && sup_dead && !sealed) |=> !sel_main);
endmodule

// File: tb/tb_bkup_rail_ctrl.sv
module tb_bkup_rail_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic sup_ok = 1'b1, sup_gt_bat = 1'b1, sup_dead = 1'b0;
    logic pf_cmp = 1'b0, pf_pin_low = 1'b0, sys_rst_n = 1'b1;
    logic sel_main, sel_bat, pf_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string tag = "R10";

    // reference model state: 0 main, 1 break, 2 cell
    int r_sw = 1;
    // seal: 0 idle, 1 qual, 2 over, 3 sealed
    int r_sl = 0;
    int r_cnt = 0;
    bit r_prev = 1'b1;

    always #5 clk = ~clk;

    bkup_rail_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sup_ok(sup_ok),
        .sup_gt_bat(sup_gt_bat), .sup_dead(sup_dead), .pf_cmp(pf_cmp),
        .pf_pin_low(pf_pin_low), .sys_rst_n(sys_rst_n),
        .sel_main(sel_main), .sel_bat(sel_bat), .pf_out(pf_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2 ms_tick <= (cyc % 4 == 3);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_sw = 1; r_sl = 0; r_cnt = 0; r_prev = 1'b1;
        end else begin
            bit want, strap;
            want  = (r_sl != 3) && (sup_dead || (!sup_ok && !sup_gt_bat));
            strap = pf_pin_low && pf_cmp && sup_ok;
            if (r_sw == 1)      r_sw = want ? 2 : 0;
            else if (r_sw == 0) r_sw = want ? 1 : 0;
            else                r_sw = want ? 2 : 1;
            if (r_sl == 0) begin
                r_cnt = 0;
                if (strap) r_sl = 1;
            end else if (r_sl == 1) begin
                if (!strap) r_sl = (r_cnt >= 5) ? 3 : 0;
                else if (ms_tick) begin
                    if (r_cnt == 35) r_sl = 2;
                    else r_cnt = r_cnt + 1;
                end
            end else if (r_sl == 2) begin
                if (!strap) r_sl = 0;
            end else if (sys_rst_n && !r_prev && sup_ok) r_sl = 0;
            r_prev = sys_rst_n;
        end
    end

    task automatic chk(bit ok, string t, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", t, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        chk(sel_main == (r_sw == 0), tag, "sel_main", int'(sel_main), int'(r_sw == 0));
        chk(sel_bat == (r_sw == 2), tag, "sel_bat", int'(sel_bat), int'(r_sw == 2));
        chk(!(sel_main && sel_bat), "R3", "both selects", 1, 0);
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #12;
        chk(!sel_main && !sel_bat, "R10", "selects in reset", int'(sel_main | sel_bat), 0);
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
        #3 chk(sel_main, "R10", "main after release", int'(sel_main), 1);
        wait_cyc(2);

        tag = "R1";
        for (int k = 0; k < 4; k++) begin
            sup_ok = k[1]; sup_gt_bat = k[0];
            wait_cyc(4);
            #3 chk(sel_bat == (k == 0), "R1", "select per combo", int'(sel_bat), int'(k == 0));
        end

        tag = "R2";
        sup_ok = 1'b0; sup_gt_bat = 1'b1; sup_dead = 1'b1;
        wait_cyc(4);
        #3 chk(sel_bat, "R2", "cell forced at minimum", int'(sel_bat), 1);
        sup_gt_bat = 1'b0;
        wait_cyc(3);
        #3 chk(sel_bat, "R2", "cell forced, gt low", int'(sel_bat), 1);
        sup_dead = 1'b0;
        wait_cyc(3);

        tag = "R4";
        sup_gt_bat = 1'b1;
        wait_cyc(1);
        #3 chk(!sel_main && !sel_bat, "R3", "break gap", int'(sel_main | sel_bat), 0);
        wait_cyc(1);
        #3 chk(sel_main, "R4", "recover on cell compare", int'(sel_main), 1);
        sup_ok = 1'b1;
        wait_cyc(2);
        sup_ok = 1'b0; sup_gt_bat = 1'b0;
        wait_cyc(4);
        sup_ok = 1'b1;
        wait_cyc(2);
        #3 chk(sel_main, "R4", "recover on threshold", int'(sel_main), 1);

        tag = "R6";
        sup_gt_bat = 1'b1;
        pf_cmp = 1'b1; pf_pin_low = 1'b1;
        wait_cyc(8);
        pf_pin_low = 1'b0;
        wait_cyc(2);
        pf_pin_low = 1'b1;
        wait_cyc(160);
        pf_pin_low = 1'b0;
        wait_cyc(2);
        sup_ok = 1'b0; sup_gt_bat = 1'b0;
        wait_cyc(3);
        #3 chk(sel_bat, "R6", "unsealed after bad straps", int'(sel_bat), 1);
        sup_ok = 1'b1; sup_gt_bat = 1'b1;
        wait_cyc(3);

        tag = "R5";
        pf_pin_low = 1'b1;
        wait_cyc(40);
        sup_ok = 1'b0; sup_gt_bat = 1'b0; pf_pin_low = 1'b0;
        tag = "R7";
        wait_cyc(5);
        #3 chk(sel_main, "R7", "sealed keeps cell off", int'(sel_bat), 0);

        tag = "R8";
        sys_rst_n = 1'b0;
        wait_cyc(2);
        sys_rst_n = 1'b1;
        wait_cyc(4);
        #3 chk(!sel_bat, "R8", "seal kept on edge with bad supply", int'(sel_bat), 0);
        sup_ok = 1'b1; sys_rst_n = 1'b0;
        wait_cyc(2);
        sys_rst_n = 1'b1;
        wait_cyc(2);
        sup_ok = 1'b0;
        wait_cyc(3);
        #3 chk(sel_bat, "R8", "seal cleared by good reset edge", int'(sel_bat), 1);

        tag = "R9";
        pf_cmp = 1'b0;
        #1 chk(pf_out == 1'b0, "R9", "pf_out low", int'(pf_out), 0);
        pf_cmp = 1'b1;
        #1 chk(pf_out == 1'b1, "R9", "pf_out high", int'(pf_out), 1);
        wait_cyc(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule